// File: doc/BRIEF.md
# Multi-Chip Linear Access Splitter

This block sits in front of an array of identical flash chips, optionally interleaved, and turns one linear byte request (start address plus length) into a series of per-chip sub-requests. Each sub-request carries a chip index, a byte offset inside that chip's window and a byte length, and never crosses into the next chip. A chip window is the chip size times the interleave count. Both chip size and interleave are powers of two, so locating the chip and the offset needs only a shift.

Requests are accepted with a valid/ready handshake. Sub-requests leave through a second valid/ready handshake, and the downstream side reports completion of each one with a response strobe and an error flag. Only one sub-request is in flight at a time. Completed bytes are accumulated. The operation ends in one of four ways: the length is used up, the chip index passes the last populated chip, a response reports an error, or the request had zero length. In every case a single-cycle done pulse carries the final byte count and the error status.

Top module: `flash_span_splitter`

## Requirements
- R1: The chip index of the first sub-request is the start address shifted right by log2 of the chip size plus log2 of the interleave count.
- R2: The offset of the first sub-request is the start address modulo the chip window (chip size times interleave). Every later sub-request of the same operation has offset 0.
- R3: A sub-request's length is the window size minus its offset when offset plus remaining length exceeds the window. Otherwise it is the whole remaining length. A sub-request is never empty and never crosses its window.
- R4: Each sub-request after the first uses the previous chip index plus one.
- R5: Splitting ends without error once the next chip index would equal the number of populated chips, even if length remains. A request that starts beyond the last chip ends with count 0, no error and no sub-request.
- R6: A response with the error flag set ends the operation at once. The done count holds only the bytes of the sub-requests completed before it, and the done error flag is 1.
- R7: A zero-length request produces no sub-request, and the done pulse with count 0 and no error comes in the cycle after acceptance.
- R8: req_ready_o is high only while idle. Sub-request fields hold steady while sub_valid_o waits for sub_ready_i. No new sub-request is offered until the previous one has received its response.
- R9: done_o is a one-cycle pulse in the cycle after the final response (or after acceptance, for a request that issues nothing). It carries the count in done_count_o and the status in done_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Linear request valid |
| req_ready_o | output | 1 | Splitter idle and able to accept a request |
| req_addr_i | input | ADDR_W | Linear start byte address |
| req_len_i | input | LEN_W | Request length in bytes |
| sub_valid_o | output | 1 | Sub-request valid |
| sub_ready_i | input | 1 | Sub-request accepted downstream |
| sub_chip_o | output | IDX_W | Chip index of the sub-request |
| sub_off_o | output | WIN_SHIFT | Byte offset within the chip window |
| sub_len_o | output | LEN_W | Sub-request length in bytes |
| rsp_valid_i | input | 1 | Completion strobe for the outstanding sub-request |
| rsp_err_i | input | 1 | Completion reports failure |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| done_count_o | output | LEN_W | Bytes completed without error |
| done_err_o | output | 1 | Operation ended on an error |

## Verification
The bench builds the splitter with an 8-bit address, an 8-bit length, 16-byte chips, two-way interleave and three chips. That gives a 32-byte window and a 96-byte populated space. With these values, short requests reach the exact window-fill boundary, a crossing by one byte, a walk across all three chips, and a start or a run past the last chip, while the 255-byte maximum length still exceeds the populated space. Varying the ready and response delays exercises field hold, and error injection on the first and on a later sub-request exercises early termination.

// File: rtl/flash_span_splitter_pkg.sv
package flash_span_splitter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } splt_state_e;
endpackage

// File: rtl/splt_addr_decode.sv
module splt_addr_decode #(
  parameter int ADDR_W    = 24,
  parameter int WIN_SHIFT = 11
) (
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [ADDR_W-WIN_SHIFT-1:0] chip_o,
  output logic [WIN_SHIFT-1:0]     off_o
);
  // divide by interleave folds into the window shift
  assign chip_o = addr_i[ADDR_W-1:WIN_SHIFT];
  assign off_o  = addr_i[WIN_SHIFT-1:0];
endmodule

// File: rtl/splt_len_clip.sv
module splt_len_clip #(
  parameter int LEN_W = 16,
  parameter int OFF_W = 11
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [LEN_W-1:0] len_o
);
  localparam int SUM_W = ((LEN_W > OFF_W) ? LEN_W : OFF_W) + 1;

  logic [SUM_W-1:0] win;
  logic [SUM_W-1:0] span;

  always_comb begin
    win   = SUM_W'(1) << OFF_W;
    span  = SUM_W'(off_i) + SUM_W'(rem_i);
    len_o = (span > win) ? LEN_W'(win - SUM_W'(off_i)) : rem_i;
  end
endmodule

// File: rtl/flash_span_splitter.sv
module flash_span_splitter
  import flash_span_splitter_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int CHIP_SHIFT = 10,
  parameter int INTLV      = 2,
  parameter int NUM_CHIPS  = 4,
  localparam int ILV_SHIFT = $clog2(INTLV),
  localparam int WIN_SHIFT = CHIP_SHIFT + ILV_SHIFT,
  localparam int CHIP_W    = ADDR_W - WIN_SHIFT,
  localparam int IDX_W     = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [LEN_W-1:0]     req_len_i,
  output logic                 sub_valid_o,
  input  logic                 sub_ready_i,
  output logic [IDX_W-1:0]     sub_chip_o,
  output logic [WIN_SHIFT-1:0] sub_off_o,
  output logic [LEN_W-1:0]     sub_len_o,
  input  logic                 rsp_valid_i,
  input  logic                 rsp_err_i,
  output logic                 done_o,
  output logic [LEN_W-1:0]     done_count_o,
  output logic                 done_err_o
);
  splt_state_e          state_q;
  logic [CHIP_W-1:0]    chip_q;
  logic [WIN_SHIFT-1:0] off_q;
  logic [LEN_W-1:0]     rem_q;
  logic [LEN_W-1:0]     cnt_q;
  logic                 done_q;
  logic                 err_q;

  logic [CHIP_W-1:0]    dec_chip;
  logic [WIN_SHIFT-1:0] dec_off;
  logic [LEN_W-1:0]     cur_len;
  logic [LEN_W-1:0]     next_rem;
  logic [CHIP_W-1:0]    next_chip;
  logic                 in_range;
  logic                 last_sub;

  splt_addr_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_SHIFT(WIN_SHIFT)
  ) u_decode (
    .addr_i(req_addr_i),
    .chip_o(dec_chip),
    .off_o (dec_off)
  );

  splt_len_clip #(
    .LEN_W(LEN_W),
    .OFF_W(WIN_SHIFT)
  ) u_clip (
    .off_i(off_q),
    .rem_i(rem_q),
    .len_o(cur_len)
  );

  always_comb begin
    next_rem  = rem_q - cur_len;
    next_chip = chip_q + CHIP_W'(1);
    in_range  = dec_chip < CHIP_W'(NUM_CHIPS);
    last_sub  = (next_rem == '0) || (next_chip == CHIP_W'(NUM_CHIPS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      chip_q  <= '0;
      off_q   <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            cnt_q <= '0;
            err_q <= 1'b0;
            if (req_len_i == '0 || !in_range) begin
              done_q <= 1'b1;
            end else begin
              chip_q  <= dec_chip;
              off_q   <= dec_off;
              rem_q   <= req_len_i;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (sub_ready_i) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid_i) begin
            if (rsp_err_i) begin
              err_q   <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cnt_q  <= cnt_q + cur_len;
              rem_q  <= next_rem;
              chip_q <= next_chip;
              off_q  <= '0;
              if (last_sub) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_ISSUE;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign sub_valid_o  = (state_q == ST_ISSUE);
  assign sub_chip_o   = chip_q[IDX_W-1:0];
  assign sub_off_o    = off_q;
  assign sub_len_o    = cur_len;
  assign done_o       = done_q;
  assign done_count_o = cnt_q;
  assign done_err_o   = err_q;
endmodule

// File: rtl/flash_span_splitter_chk.sv
module flash_span_splitter_chk #(
  parameter int LEN_W     = 16,
  parameter int WIN_SHIFT = 11,
  parameter int IDX_W     = 2,
  parameter int NUM_CHIPS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_ready_o,
  input logic                 sub_valid_o,
  input logic                 sub_ready_i,
  input logic [IDX_W-1:0]     sub_chip_o,
  input logic [WIN_SHIFT-1:0] sub_off_o,
  input logic [LEN_W-1:0]     sub_len_o
);
  localparam int SUM_W = ((LEN_W > WIN_SHIFT) ? LEN_W : WIN_SHIFT) + 1;
  localparam logic [SUM_W-1:0] WIN = SUM_W'(1) << WIN_SHIFT;

  // R8
  sub_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && !sub_ready_i |=> sub_valid_o && $stable(sub_chip_o)
      && $stable(sub_off_o) && $stable(sub_len_o));

  // R3
  sub_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o |-> (sub_len_o != '0) && ((SUM_W'(sub_off_o) + SUM_W'(sub_len_o)) <= WIN));

  // R5
  chip_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o |-> (int'(sub_chip_o) < NUM_CHIPS));

  // R8
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o |-> !req_ready_o);

  // R8
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && sub_ready_i |=> !sub_valid_o);
endmodule

bind flash_span_splitter flash_span_splitter_chk #(
  .LEN_W    (LEN_W),
  .WIN_SHIFT(WIN_SHIFT),
  .IDX_W    (IDX_W),
  .NUM_CHIPS(NUM_CHIPS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .sub_valid_o(sub_valid_o),
  .sub_ready_i(sub_ready_i),
  .sub_chip_o (sub_chip_o),
  .sub_off_o  (sub_off_o),
  .sub_len_o  (sub_len_o)
);

// File: tb/flash_span_splitter_test.sv
`timescale 1ns/1ps
module flash_span_splitter_test;
  localparam int AW = 8, LW = 8, CS = 4, IL = 2, NC = 3;
  localparam int WIN = (1 << CS) * IL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          sub_valid, sub_ready = 1'b0;
  logic [1:0]    sub_chip;
  logic [4:0]    sub_off;
  logic [LW-1:0] sub_len;
  logic          rsp_valid = 1'b0, rsp_err = 1'b0;
  logic          done, done_err;
  logic [LW-1:0] done_count;

  flash_span_splitter #(
    .ADDR_W(AW), .LEN_W(LW), .CHIP_SHIFT(CS), .INTLV(IL), .NUM_CHIPS(NC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len),
    .sub_valid_o(sub_valid), .sub_ready_i(sub_ready),
    .sub_chip_o(sub_chip), .sub_off_o(sub_off), .sub_len_o(sub_len),
    .rsp_valid_i(rsp_valid), .rsp_err_i(rsp_err),
    .done_o(done), .done_count_o(done_count), .done_err_o(done_err)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int q_chip[$], q_off[$], q_len[$];
  int exp_cnt, exp_err;

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: expected sub-request list and final result
  task automatic build(int addr, int len, int err_at);
    int chip, off, rem, l, idx;
    q_chip.delete(); q_off.delete(); q_len.delete();
    chip = addr / WIN; off = addr % WIN; rem = len; idx = 0;
    exp_cnt = 0; exp_err = 0;
    while (rem > 0 && chip < NC) begin
      l = (off + rem > WIN) ? WIN - off : rem;
      q_chip.push_back(chip); q_off.push_back(off); q_len.push_back(l);
      if (idx == err_at) begin exp_err = 1; break; end
      exp_cnt += l; rem -= l; chip++; off = 0; idx++;
    end
  endtask

  task automatic check_sub(int i);
    cmp("R8 sub_valid offered", int'(sub_valid), 1);
    cmp(i == 0 ? "R1 first chip index" : "R4 chip step", int'(sub_chip), q_chip[i]);
    cmp("R2 offset", int'(sub_off), q_off[i]);
    cmp("R3 length", int'(sub_len), q_len[i]);
    cmp("R8 req_ready busy", int'(req_ready), 0);
  endtask

  task automatic run(string dtag, int addr, int len, int err_at, int rdy_dly, int rsp_dly);
    build(addr, len, err_at);
    @(negedge clk);
    cmp("R8 req_ready idle", int'(req_ready), 1);
    req_valid = 1'b1; req_addr = AW'(addr); req_len = LW'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (q_chip.size() == 0) begin
      cmp({dtag, " done pulse"}, int'(done), 1);
      cmp({dtag, " count"}, int'(done_count), exp_cnt);
      cmp({dtag, " error"}, int'(done_err), exp_err);
      cmp({dtag, " no sub"}, int'(sub_valid), 0);
    end else begin
      cmp("R9 no early done", int'(done), 0);
      for (int i = 0; i < q_chip.size(); i++) begin
        for (int k = 0; k < rdy_dly; k++) begin
          check_sub(i);
          @(negedge clk);
        end
        check_sub(i);
        sub_ready = 1'b1;
        @(negedge clk);
        sub_ready = 1'b0;
        for (int k = 0; k < rsp_dly; k++) begin
          cmp("R8 no sub while waiting", int'(sub_valid), 0);
          cmp("R9 no done while waiting", int'(done), 0);
          @(negedge clk);
        end
        cmp("R8 no sub while waiting", int'(sub_valid), 0);
        rsp_valid = 1'b1; rsp_err = (i == err_at);
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
        if (i == q_chip.size() - 1) begin
          cmp({dtag, " done pulse"}, int'(done), 1);
          cmp({dtag, " count"}, int'(done_count), exp_cnt);
          cmp({dtag, " error"}, int'(done_err), exp_err);
        end else begin
          cmp("R9 no done mid-operation", int'(done), 0);
        end
      end
    end
    @(negedge clk);
    cmp("R9 done one cycle", int'(done), 0);
    cmp("R8 idle after done", int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R8 reset req_ready", int'(req_ready), 1);
    cmp("R8 reset sub_valid", int'(sub_valid), 0);
    cmp("R9 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run("R9 single",        0,   10, -1, 0, 0);
    run("R3 exact fill",    5,   27, -1, 1, 0);
    run("R3 cross by one",  5,   28, -1, 0, 1);
    run("R2 mid chip",      40,  50, -1, 2, 2);
    run("R5 past last",     0,  200, -1, 0, 0);
    run("R5 remaining",     33,  64, -1, 3, 1);
    run("R7 zero length",   70,   0, -1, 0, 0);
    run("R5 start beyond",  100,  5, -1, 0, 0);
    run("R6 later error",   10,  80,  1, 1, 1);
    run("R6 first error",   64,  20,  0, 0, 2);
    run("R9 after error",   95,   1, -1, 0, 0);
    run("R4 full walk",     31,  66, -1, 1, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule